// File: doc/BRIEF.md
# USB Device Suspend/Resume Power Controller

This block manages the low-power state of a USB device function. It watches a suspend level reported by the device core. Each change of that level becomes one event. The event sets a shared interrupt flag and updates a readable suspended status bit. Bus-master transfers are not touched; software decides whether to abort them after it takes the interrupt.

Software puts the PHY into suspend through a control bit, which drives an active-low PHY suspend output. Leaving suspend needs no software write. A resume event from the host releases the PHY suspend output in hardware. A remote wakeup does the same: one control write raises the wakeup request to the core and releases PHY suspend in the same cycle. The request is held until the PHY reports its clock valid again.

When the system bus clock is stopped and wake reporting is enabled, a host resume also pulls a separate active-low wake output low. The wake output stays low until the bus clock runs again.

Top module: `usb_pwr_ctrl`

## Requirements
- R1: After reset, phy_suspend_no and wake_no are 1, irq_o and core_wakeup_o are 0, and the control and status registers read 0.
- R2: A 0-to-1 change of core_susp_i sets the interrupt flag and the suspended status bit three clock edges after the change. Status register (address 1) bit 0 is suspended and bit 1 is the interrupt flag; irq_o follows the flag.
- R3: Writing a value with bit 0 set to the clear register (address 2) clears the interrupt flag at the next edge.
- R4: Control register (address 0) bit 0 requests PHY suspend. Writing it as 1 drives phy_suspend_no low at the next edge.
- R5: A suspend or resume event that lands in the same cycle as a clear write leaves the interrupt flag set.
- R6: A 1-to-0 change of core_susp_i sets the interrupt flag, clears the suspended bit and releases phy_suspend_no, all three edges after the change, with no software write.
- R7: Writing 1 to control bit 1 while suspended raises core_wakeup_o and releases phy_suspend_no at the next edge. The same write is ignored when not suspended. A PHY suspend request written while the wakeup is pending is ignored.
- R8: core_wakeup_o stays high until phy_clk_valid_i is seen high, and drops at the edge that samples it.
- R9: With control bit 2 (wake enable) set and bus_clk_stop_i high, a resume event drives wake_no low together with the interrupt. wake_no returns high one edge after bus_clk_stop_i falls. With wake enable clear, wake_no stays high.
- R10: A held core_susp_i level produces exactly one event; once that event is cleared, no further interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_susp_i | input | 1 | Suspend level from device core (asynchronous) |
| phy_clk_valid_i | input | 1 | PHY clock running indication |
| bus_clk_stop_i | input | 1 | System bus clock stopped |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Suspend/resume interrupt |
| phy_suspend_no | output | 1 | PHY suspend, active low |
| core_wakeup_o | output | 1 | Remote wakeup request to core |
| wake_no | output | 1 | Wake event while bus clock stopped, active low |

## Verification
Events from core_susp_i are due exactly three edges after the input changes: two synchronizer flops plus the flag register. Register writes, the PHY clock-valid release and the wake release take effect one edge after the stimulus, and register reads are combinational. The driver stamps every expected value with its due cycle, counted from the edge counter at the moment of stimulus. The monitor compares that value only in that cycle, half a period after the edge, and also checks the cycle before, so an early result is caught as well as a late one. The event-versus-clear race is set up by timing the clear write to the edge where the event lands.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_ICLR = 2'd2;

  localparam int unsigned CTRL_PHY = 0;
  localparam int unsigned CTRL_RWK = 1;
  localparam int unsigned CTRL_WEN = 2;

  localparam int unsigned STAT_SUSP = 0;
  localparam int unsigned STAT_IRQ  = 1;
endpackage

// File: rtl/pwr_sync_edge.sv
module pwr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= async_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R10
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R10
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import usb_pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              susp_ev_i,
  input  logic              res_ev_i,
  input  logic              clk_valid_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o,
  output logic              phy_susp_o,
  output logic              rwk_o,
  output logic              wake_en_o,
  output logic              suspended_o
);
  logic phy_q, rwk_q, wen_q, susp_q, irq_q;
  logic wr_ctrl, wr_iclr, rwk_set, any_ev;
  logic unused_wdata;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_iclr = we_i && (addr_i == ADDR_ICLR);
  assign rwk_set = wr_ctrl && wdata_i[CTRL_RWK] && susp_q;
  assign any_ev  = susp_ev_i || res_ev_i;
  assign unused_wdata = ^wdata_i[REG_DW-1:CTRL_WEN+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q  <= 1'b0;
      rwk_q  <= 1'b0;
      wen_q  <= 1'b0;
      susp_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // hardware release beats software request
      if (res_ev_i || rwk_set)     phy_q <= 1'b0;
      else if (wr_ctrl && !rwk_q)  phy_q <= wdata_i[CTRL_PHY];

      if (rwk_set)          rwk_q <= 1'b1;
      else if (clk_valid_i) rwk_q <= 1'b0;

      if (wr_ctrl) wen_q <= wdata_i[CTRL_WEN];

      if (susp_ev_i)     susp_q <= 1'b1;
      else if (res_ev_i) susp_q <= 1'b0;

      // event wins over clear
      if (any_ev)                       irq_q <= 1'b1;
      else if (wr_iclr && wdata_i[0])   irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_PHY] = phy_q;
        rdata_o[CTRL_RWK] = rwk_q;
        rdata_o[CTRL_WEN] = wen_q;
      end
      ADDR_STAT: begin
        rdata_o[STAT_SUSP] = susp_q;
        rdata_o[STAT_IRQ]  = irq_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o       = irq_q;
  assign phy_susp_o  = phy_q;
  assign rwk_o       = rwk_q;
  assign wake_en_o   = wen_q;
  assign suspended_o = susp_q;

  // R3
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_iclr && wdata_i[0] && !any_ev) |=> !irq_q);
  // R5
  ev_over_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ev |=> irq_q);
  // R6
  resume_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ev_i |=> (!phy_q && !susp_q));
  // R7
  rwk_blocks_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwk_q |-> !phy_q);
  // R8
  rwk_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwk_q && clk_valid_i && !rwk_set) |=> !rwk_q);
endmodule

// File: rtl/pwr_wake.sv
module pwr_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_en_i,
  input  logic bus_clk_stop_i,
  input  logic res_ev_i,
  output logic wake_no
);
  logic wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     wake_q <= 1'b0;
    else if (!bus_clk_stop_i)                        wake_q <= 1'b0;
    else if (res_ev_i && wake_en_i)                  wake_q <= 1'b1;
  end

  assign wake_no = ~wake_q;

  // R9
  wake_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clk_stop_i |=> wake_no);
  // R9
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ev_i && wake_en_i && bus_clk_stop_i) |=> !wake_no);
endmodule

// File: rtl/usb_pwr_ctrl.sv
module usb_pwr_ctrl
  import usb_pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_susp_i,
  input  logic              phy_clk_valid_i,
  input  logic              bus_clk_stop_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              phy_suspend_no,
  output logic              core_wakeup_o,
  output logic              wake_no
);
  logic susp_ev, res_ev, phy_susp, wake_en, suspended;
  logic unused_susp;

  pwr_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (core_susp_i),
    .rise_o  (susp_ev),
    .fall_o  (res_ev)
  );

  pwr_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .susp_ev_i   (susp_ev),
    .res_ev_i    (res_ev),
    .clk_valid_i (phy_clk_valid_i),
    .rdata_o     (reg_rdata_o),
    .irq_o       (irq_o),
    .phy_susp_o  (phy_susp),
    .rwk_o       (core_wakeup_o),
    .wake_en_o   (wake_en),
    .suspended_o (suspended)
  );

  pwr_wake i_wake (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wake_en_i      (wake_en),
    .bus_clk_stop_i (bus_clk_stop_i),
    .res_ev_i       (res_ev),
    .wake_no        (wake_no)
  );

  assign phy_suspend_no = ~phy_susp;
  assign unused_susp    = suspended;

  // R7
  wakeup_vs_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wakeup_o |-> phy_suspend_no);
endmodule

// File: tb/test_usb_pwr_ctrl.sv
module test_usb_pwr_ctrl;
  import usb_pwr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_susp = 1'b0, clk_valid = 1'b1, bus_stop = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = ADDR_STAT;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, phy_n, wk, wake_n;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [11:0] mask;
    logic [11:0] val;
    string       req;
  } item_t;
  item_t sb[$];

  localparam logic [11:0] M_IRQ = 12'h001, M_PHY = 12'h002, M_WK = 12'h004,
                          M_WAKE = 12'h008, M_RD = 12'hFF0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usb_pwr_ctrl i_usb_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .core_susp_i(core_susp),
    .phy_clk_valid_i(clk_valid), .bus_clk_stop_i(bus_stop),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .phy_suspend_no(phy_n),
    .core_wakeup_o(wk), .wake_no(wake_n)
  );

  task automatic exp_at(int off, logic [11:0] m, logic [11:0] v, string r);
    item_t it;
    it.due = cyc + off; it.mask = m; it.val = v; it.req = r;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = ADDR_STAT; wdata = '0;
  endtask

  // monitor: compare items due in this cycle
  always @(negedge clk) begin
    logic [11:0] obs;
    #1;
    obs = {rdata, wake_n, wk, phy_n, irq};
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        n_tests++;
        if ((obs & sb[i].mask) !== sb[i].val || sb[i].due != cyc) begin
          n_fail++;
          $display("FAIL %s cyc=%0d actual=%h expected=%h mask=%h", sb[i].req,
                   cyc, obs & sb[i].mask, sb[i].val, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    exp_at(0, M_IRQ | M_PHY | M_WK | M_WAKE | M_RD, 12'h00A, "R1");
    step(1);
    addr = ADDR_CTRL; #1;
    n_tests++;
    if (rdata !== 8'h00) begin
      n_fail++; $display("FAIL R1 ctrl actual=%h expected=00", rdata);
    end
    addr = ADDR_STAT;
    step(1);

    // R2 suspend event, three edges
    core_susp = 1'b1;
    exp_at(2, M_IRQ | M_RD, 12'h000, "R2");
    exp_at(3, M_IRQ | M_RD, 12'h031, "R2");
    step(4);

    // R3 clear, then R10 no repeat event while level held
    exp_at(1, M_IRQ | M_RD, 12'h010, "R3");
    for (int k = 2; k <= 6; k++) exp_at(k, M_IRQ, 12'h000, "R10");
    wr(ADDR_ICLR, 8'h01);
    step(6);

    // R4 phy suspend request
    exp_at(1, M_PHY, 12'h000, "R4");
    wr(ADDR_CTRL, 8'h01);
    step(1);

    // R5 + R6: resume event meets clear write
    core_susp = 1'b0;
    exp_at(2, M_IRQ | M_PHY, 12'h000, "R6");
    exp_at(3, M_IRQ, 12'h001, "R5");
    exp_at(3, M_PHY | M_RD, 12'h022, "R6");
    step(2);
    wr(ADDR_ICLR, 8'h01);
    step(2);
    wr(ADDR_ICLR, 8'h01);

    // R7 remote wakeup while suspended
    core_susp = 1'b1;
    step(4);
    wr(ADDR_ICLR, 8'h01);
    wr(ADDR_CTRL, 8'h01);
    clk_valid = 1'b0;
    exp_at(0, M_PHY, 12'h000, "R4");
    exp_at(1, M_PHY | M_WK, 12'h006, "R7");
    wr(ADDR_CTRL, 8'h03);
    exp_at(1, M_PHY | M_WK, 12'h006, "R7");
    wr(ADDR_CTRL, 8'h01);
    exp_at(3, M_WK, 12'h004, "R8");
    step(3);
    clk_valid = 1'b1;
    exp_at(1, M_WK | M_PHY, 12'h002, "R8");
    step(2);

    // R7 ignored when not suspended
    core_susp = 1'b0;
    step(4);
    wr(ADDR_ICLR, 8'h01);
    clk_valid = 1'b0;
    exp_at(1, M_WK, 12'h000, "R7");
    wr(ADDR_CTRL, 8'h02);
    addr = ADDR_CTRL; #1;
    n_tests++;
    if (rdata !== 8'h00) begin
      n_fail++; $display("FAIL R7 ctrl actual=%h expected=00", rdata);
    end
    addr = ADDR_STAT;
    clk_valid = 1'b1;
    step(1);

    // R9 wake with enable and stopped bus clock
    wr(ADDR_CTRL, 8'h04);
    bus_stop = 1'b1;
    core_susp = 1'b1;
    step(4);
    wr(ADDR_ICLR, 8'h01);
    core_susp = 1'b0;
    exp_at(2, M_WAKE, 12'h008, "R9");
    exp_at(3, M_WAKE | M_IRQ, 12'h001, "R9");
    step(4);
    bus_stop = 1'b0;
    exp_at(1, M_WAKE, 12'h008, "R9");
    step(1);
    wr(ADDR_ICLR, 8'h01);

    // R9 no wake when disabled
    wr(ADDR_CTRL, 8'h00);
    bus_stop = 1'b1;
    core_susp = 1'b1;
    step(4);
    wr(ADDR_ICLR, 8'h01);
    core_susp = 1'b0;
    exp_at(3, M_WAKE | M_IRQ, 12'h009, "R9");
    step(4);
    bus_stop = 1'b0;
    step(2);

    while (sb.size() != 0) step(1);
    step(2);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule